// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous SRAM. It has one shared data bus, which is modelled as separate input, output and output-enable signals. Reads and writes have the same two-edge latency. A command can therefore be accepted on every clock with no turnaround gap. A write supplies its address on one rising edge, and its data is taken from the bus on the second rising edge after that. During that time the next command is already being accepted. A read's data sits on the bus so that the host samples it on the second rising edge after the read address.

A short burst needs only one external address. Holding advance/load high continues the previous operation at the next word of an aligned four-word block, and the chip enables and write enable are ignored while it does. Per-lane byte selects mask which lanes a write changes. A clock-enable input freezes the whole pipeline. The asynchronous sleep input passes through a two-stage synchronizer. While the block is asleep it drops pending work, ignores commands, keeps its array and releases the bus.

Top module: `lw_sram`

## Requirements
- R1: A command is accepted on a rising edge when cke_n is low and adv_ld is low. It is a read if all three chip enables are active (ce1_n low, ce2 high, ce3_n low) and we_n is high. It is a write if all three chip enables are active and we_n is low. With any chip enable inactive it is a deselect, which neither drives the bus nor changes the array.
- R2: Read data for an address accepted on edge k is present on dq_out, with dq_oe high (given oe_n low), between edge k+1 and edge k+2.
- R3: Write data on dq_in is captured on edge k+2 for a write address accepted on edge k. Back-to-back writes and reads need no idle cycle, and a read issued right after a write to the same word returns the newly written lanes.
- R4: Lane i of a word occupies bits [i*LANE_W +: LANE_W]. A write changes lane i only if bw_n[i] is low on the edge of its address or burst beat. All other lanes keep their contents.
- R5: During a write's data phase (between edges k+1 and k+2) dq_oe is low whatever oe_n is.
- R6: While oe_n is high, dq_oe is low.
- R7: A burst beat is an edge with adv_ld high and cke_n low. It repeats the previous operation at an address whose two low bits are incremented modulo 4, with the upper bits held. The chip enables and we_n are ignored. After a deselect, a burst beat is also a deselect.
- R8: bw_n is sampled afresh on every burst-write beat.
- R9: While cke_n is high, no state changes: the array, the pipeline and dq_out all hold.
- R10: sleep is synchronized by two flip-flops. While the synchronized sleep is high, dq_oe is low, accepted commands are discarded, pending accesses are dropped and array contents are kept. Operation resumes two edges after sleep falls.
- R11: After synchronous reset (rst_n low), dq_oe is low and dq_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_n | input | 1 | Clock enable, low active; high stalls everything |
| ce1_n | input | 1 | Chip enable 1, low active |
| ce2 | input | 1 | Chip enable 2, high active |
| ce3_n | input | 1 | Chip enable 3, low active |
| we_n | input | 1 | Write enable, low active |
| adv_ld | input | 1 | Low loads a new command, high advances a burst |
| bw_n | input | LANES | Per-lane write select, low active |
| oe_n | input | 1 | Output enable, low active |
| sleep | input | 1 | Asynchronous sleep request |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Data bus, inbound |
| dq_out | output | LANES*LANE_W | Data bus, outbound value |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench builds the block with ADDR_W=6, LANES=4 and LANE_W=9, which gives 64 words of 36 bits. At that size every word can be preloaded, and random addresses often hit the same word. Same-word write-then-read forwarding and wrap-around inside the four-word burst blocks therefore come up many times in the random run. Four lanes with a ninth bit each exercise sparse masks and the extra bit of each lane. Stalls, oe_n highs and sleep episodes are mixed into the random traffic, so they overlap bursts and write data phases.

// File: rtl/lw_sram_pkg.sv
// Shared types for the late-write SRAM model.
package lw_sram_pkg;
    // Operation held in a pipeline stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/lw_sram_sleep_sync.sv
// Two-flop synchronizer for the asynchronous sleep request.
// Assumes: sleep may change at any time; output is valid two edges later.
module lw_sram_sleep_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_in,
    output logic asleep
);
    logic stage0;

    // Shift the request through two flops; runs even while the clock enable is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage0 <= 1'b0;
            asleep <= 1'b0;
        end else begin
            stage0 <= sleep_in;
            asleep <= stage0;
        end
    end

    AST_SLEEP_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(sleep_in)); // R10
endmodule

// File: rtl/lw_sram_cmd.sv
// Command decode, address register and two-bit burst counter (pipeline stage 1).
// Assumes: ADDR_W >= 2; a burst wraps inside an aligned four-word block.
module lw_sram_cmd
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              asleep,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic              adv_ld,
    input  logic [LANES-1:0]  bw_n,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op1,
    output logic [ADDR_W-1:0] addr1,
    output logic [LANES-1:0]  lanes1
);
    localparam int HI_W = ADDR_W - 2;

    logic sel;
    assign sel = !ce1_n && ce2 && !ce3_n;

    // Load a new command or advance the current burst on each enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op1    <= OP_IDLE;
            addr1  <= '0;
            lanes1 <= '0;
        end else if (en) begin
            if (asleep) begin
                op1 <= OP_IDLE;
            end else if (!adv_ld) begin
                op1    <= !sel ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
                addr1  <= addr;
                lanes1 <= ~bw_n;
            end else begin
                addr1  <= {addr1[ADDR_W-1:2], addr1[1:0] + 2'd1};
                lanes1 <= ~bw_n;
            end
        end
    end

    AST_BURST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !asleep && adv_ld && op1 != OP_IDLE) |=>
        (addr1[1:0] == $past(addr1[1:0]) + 2'd1 &&
         addr1[ADDR_W-1:2] == $past(addr1[ADDR_W-1:2]) && op1 == $past(op1))); // R7

    AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !asleep && !adv_ld && (ce1_n || !ce2 || ce3_n)) |=> op1 == OP_IDLE); // R1

    if (HI_W < 0) begin : g_bad_width
        initial $error("lw_sram_cmd: ADDR_W must be at least 2");
    end
endmodule

// File: rtl/lw_sram_array.sv
// Lane-split storage array with masked write and a registered, forwarded read.
// Assumes: a write and a read to one word on the same edge return the new lanes.
module lw_sram_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] fwd;
    logic              same;

    assign same = wr_en && (wr_addr == rd_addr);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Commit this lane when the write selects it.
        always_ff @(posedge clk) begin
            if (en && wr_en && wr_lanes[l]) begin
                cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
        end

        // Read this lane, taking the incoming write when it targets the same word.
        assign fwd[l*LANE_W +: LANE_W] = (same && wr_lanes[l]) ?
            wr_data[l*LANE_W +: LANE_W] : cells[rd_addr];
    end

    // Output register: loads on a read, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (en && rd_en) begin
            rd_q <= fwd;
        end
    end

    AST_RDQ_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rd_q)); // R9
endmodule

// File: rtl/lw_sram.sv
// Top of the pipelined late-write SRAM: stage 2 (data phase) and bus control.
// Assumes: the host releases the bus while dq_oe is high; oe_n acts without a clock.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              we_n,
    input  logic              adv_ld,
    input  logic [LANES-1:0]  bw_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);
    logic              asleep;
    op_e               op1, op2;
    logic [ADDR_W-1:0] addr1, addr2;
    logic [LANES-1:0]  lanes1, lanes2;
    logic              go;

    assign go = !cke_n && !asleep;

    lw_sram_sleep_sync u_sleep (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_in (sleep),
        .asleep   (asleep)
    );

    lw_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (!cke_n),
        .asleep (asleep),
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .ce3_n  (ce3_n),
        .we_n   (we_n),
        .adv_ld (adv_ld),
        .bw_n   (bw_n),
        .addr   (addr),
        .op1    (op1),
        .addr1  (addr1),
        .lanes1 (lanes1)
    );

    // Stage 2: the data phase of the operation accepted one edge earlier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op2    <= OP_IDLE;
            addr2  <= '0;
            lanes2 <= '0;
        end else if (!cke_n) begin
            op2    <= asleep ? OP_IDLE : op1;
            addr2  <= addr1;
            lanes2 <= lanes1;
        end
    end

    lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (go),
        .wr_en    (op2 == OP_WRITE),
        .wr_addr  (addr2),
        .wr_lanes (lanes2),
        .wr_data  (dq_in),
        .rd_en    (op1 == OP_READ),
        .rd_addr  (addr1),
        .rd_q     (dq_out)
    );

    // Drive the bus only in a read data phase with output enable on and awake.
    assign dq_oe = (op2 == OP_READ) && !oe_n && !asleep;

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe); // R6
    AST_WRITE_PHASE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (op2 == OP_WRITE) |-> !dq_oe); // R5
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(dq_out)); // R9
    AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        asleep |-> !dq_oe); // R10
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (dq_out == '0 && !dq_oe)); // R11
endmodule

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;
    localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW, DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, cke_n = 1'b0, ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
    logic we_n = 1'b1, adv_ld = 1'b0, oe_n = 1'b0, sleep = 1'b0;
    logic [LN-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe;

    lw_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .we_n(we_n), .adv_ld(adv_ld), .bw_n(bw_n), .oe_n(oe_n),
        .sleep(sleep), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    int n_chk = 0, n_bad = 0;
    string tag = "R11 reset";
    logic oe_v = 1'b0, slp_v = 1'b0;

    // Reference model state (0 idle, 1 read, 2 write).
    logic [DW-1:0] ref_mem [DEPTH];
    int m1_op = 0, m2_op = 0;
    logic [AW-1:0] m1_a = '0, m2_a = '0;
    logic [LN-1:0] m1_bw = '0, m2_bw = '0;
    logic [DW-1:0] m_rq = '0;
    logic sy0 = 1'b0, sy1 = 1'b0;

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                            logic [LN-1:0] mask);
        logic [DW-1:0] r = old_w;
        for (int l = 0; l < LN; l++)
            if (mask[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
        return r;
    endfunction

    // Advance the reference model by one rising edge using the applied inputs.
    task automatic model_edge();
        logic was_asleep;
        if (!rst_n) begin
            m1_op = 0; m2_op = 0; m_rq = '0; sy0 = 1'b0; sy1 = 1'b0;
            m1_a = '0; m2_a = '0; m1_bw = '0; m2_bw = '0;
        end else begin
            was_asleep = sy1;
            sy1 = sy0;
            sy0 = sleep;
            if (!cke_n) begin
                if (was_asleep) begin
                    m1_op = 0; m2_op = 0;
                end else begin
                    if (m2_op == 2) ref_mem[m2_a] = merge(ref_mem[m2_a], dq_in, m2_bw);
                    if (m1_op == 1) m_rq = ref_mem[m1_a];
                    m2_op = m1_op; m2_a = m1_a; m2_bw = m1_bw;
                    if (!adv_ld) begin
                        m1_op = (!ce1_n && ce2 && !ce3_n) ? (we_n ? 1 : 2) : 0;
                        m1_a = addr;
                    end else begin
                        m1_a = {m1_a[AW-1:2], m1_a[1:0] + 2'd1};
                    end
                    m1_bw = ~bw_n;
                end
            end
        end
    endtask

    task automatic check();
        logic e_oe;
        e_oe = (m2_op == 1) && !oe_n && !sy1;
        n_chk++;
        if (dq_oe !== e_oe) begin
            n_bad++;
            $display("FAIL %s: dq_oe=%b expected %b at %0t", tag, dq_oe, e_oe, $time);
        end
        n_chk++;
        if (dq_out !== m_rq) begin
            n_bad++;
            $display("FAIL %s: dq_out=%h expected %h at %0t", tag, dq_out, m_rq, $time);
        end
    endtask

    // One cycle: check the last edge's outputs, apply inputs, take the edge.
    task automatic step(input logic ck, input logic [2:0] ce, input logic w, input logic av,
                        input logic [LN-1:0] b, input logic [AW-1:0] a);
        @(negedge clk);
        check();
        cke_n = ck; ce1_n = !ce[0]; ce2 = ce[1]; ce3_n = !ce[2];
        we_n = w; adv_ld = av; bw_n = b; addr = a;
        oe_n = oe_v; sleep = slp_v;
        dq_in = DW'({$urandom, $urandom});
        @(posedge clk);
        #1;
        model_edge();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] b);
        step(1'b0, 3'b111, 1'b0, 1'b0, b, a);
    endtask
    task automatic rd(input logic [AW-1:0] a);
        step(1'b0, 3'b111, 1'b1, 1'b0, '1, a);
    endtask
    task automatic cont(input logic [LN-1:0] b);   // chip enables off, we low: must be ignored
        step(1'b0, 3'b000, 1'b0, 1'b1, b, '0);
    endtask
    task automatic nop();
        step(1'b0, 3'b101, 1'b1, 1'b0, '1, '0);
    endtask
    task automatic stall();
        step(1'b1, 3'b111, 1'b0, 1'b0, '0, AW'($urandom));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1..: run did not complete, actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1460));
        repeat (3) @(posedge clk);
        #1 model_edge();
        @(negedge clk) rst_n = 1'b1;
        // R11: reset state checked by the first step's check.
        nop();
        tag = "R3 preload";
        for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0);
        nop(); nop();
        tag = "R1 deselected write leaves array";
        step(1'b0, 3'b011, 1'b0, 1'b0, '0, 6'd9);
        rd(6'd9); nop(); nop();
        tag = "R2 R3 back-to-back forwarding";
        wr(6'd9, '0); rd(6'd9); wr(6'd10, '0); rd(6'd10); rd(6'd9); nop(); nop();
        tag = "R4 lane mask";
        wr(6'd12, 4'b1010); rd(6'd12); nop(); nop();
        tag = "R7 R8 burst write wrap";
        wr(6'd6, 4'b0000); cont(4'b0111); cont(4'b1111); cont(4'b0000); nop(); nop();
        tag = "R7 burst read wrap";
        rd(6'd4); cont('1); cont('1); cont('1); cont('1); nop(); nop();
        rd(6'd7); cont('1); nop(); nop();
        tag = "R7 burst after deselect";
        nop(); cont('0); cont('0); nop(); rd(6'd4); nop(); nop();
        tag = "R5 R6 bus release";
        wr(6'd20, '0); rd(6'd20); nop();
        oe_v = 1'b1; rd(6'd20); nop(); nop(); oe_v = 1'b0; nop();
        tag = "R9 stall";
        rd(6'd9); stall(); stall(); stall(); nop(); wr(6'd9, '0); stall(); stall(); nop(); rd(6'd9); nop(); nop();
        tag = "R10 sleep";
        nop(); slp_v = 1'b1; nop(); nop(); rd(6'd9); wr(6'd9, '0); nop(); nop();
        slp_v = 1'b0; nop(); nop(); nop(); rd(6'd9); nop(); nop();
        tag = "R1 R2 R3 R4 R7 R8 R9 R10 random";
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] ce;
            if ($urandom % 300 == 0) slp_v = !slp_v;
            oe_v = ($urandom % 8 == 0);
            ce = ($urandom % 8 == 0) ? 3'(~(3'b1 << ($urandom % 3))) : 3'b111;
            step(($urandom % 8 == 0), ce, 1'($urandom), ($urandom % 4 == 0),
                 LN'($urandom), AW'($urandom));
        end
        slp_v = 1'b0; oe_v = 1'b0;
        nop(); nop(); nop(); nop();
        @(negedge clk);
        check();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule